// File: doc/BRIEF.md
# Interruptible Multi-Word Transfer Sequencer

This block turns one load-multiple or store-multiple operation into a chain of single-word bus accesses. It takes a base address, a mask that selects registers, and a direction. For each selected register it issues one access and reports which register that access belongs to. The surrounding datapath then routes the data to or from the register file.

Between two accesses the sequencer may give up the operation so that a more urgent exception can be taken. It does this only if three things hold: the abandonment control bit is clear, the pending exception outranks the current execution level, and the access that has just finished was to a Normal memory region. When it gives up, it presents a resume point: the next register index and the address for it. A later resume request with that point finishes the rest of the registers instead of starting again from the first one.

Top module: `burst_xfer_seq`

## Requirements
- R1: While `rst_ni` is low, `busy_o`, `mem_req_o`, `done_o` and `abandon_o` are all 0.
- R2: After `start_i` is accepted, the block makes one access for each set bit of `reg_mask_i`, in ascending register index. The k-th access (counting from 0) has `mem_addr_o` = `base_addr_i` + 4*k and `mem_reg_o` equal to that register index. `mem_we_o` equals `store_i`, where 1 means store and 0 means load.
- R3: A request stays asserted, with `mem_addr_o` and `mem_reg_o` unchanged, until `mem_ack_i` is sampled high. An access in flight is never withdrawn.
- R4: `done_o` is high for exactly one cycle. That cycle is the one after the last acknowledge, and `busy_o` is 0 in it. With an empty mask, `done_o` pulses in the cycle after `start_i` and no request is made.
- R5: Abandonment happens when `no_abandon_i`=0, `exc_pend_i`=1, `exc_prio_i` < `cur_prio_i` (a smaller number means higher priority), and `mem_dev_i`=0 at the acknowledge, with registers still remaining. In that case `abandon_o` pulses for one cycle in the cycle after the acknowledge and no further request follows. `rst_idx_o` and `rst_addr_o` then give the next register and its address.
- R6: When `no_abandon_i`=1, the operation always runs to `done_o`.
- R7: When `mem_dev_i`=1 at an acknowledge, which marks a Device or Strongly-ordered region, the block does not abandon at that boundary.
- R8: When `exc_prio_i` >= `cur_prio_i`, the block never abandons.
- R9: The final access of an operation always ends in `done_o` and never in `abandon_o`.
- R10: `resume_i` continues at `resume_addr_i` with the set bits of `reg_mask_i` whose index is >= `resume_idx_i`, in ascending order, at 4-byte steps.
- R11: `start_i` and `resume_i` are ignored while `busy_o` is 1. If both are high in the same idle cycle, `start_i` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a new operation |
| resume_i | input | 1 | Continue an abandoned operation |
| base_addr_i | input | AW | Start address for `start_i` |
| reg_mask_i | input | NREG | Register selection mask |
| store_i | input | 1 | 1 = store, 0 = load |
| resume_idx_i | input | clog2(NREG) | Register index at which to resume |
| resume_addr_i | input | AW | Address at which to resume |
| no_abandon_i | input | 1 | 1 disables abandonment |
| exc_pend_i | input | 1 | An exception is pending |
| exc_prio_i | input | PW | Priority of the pending exception (smaller is more urgent) |
| cur_prio_i | input | PW | Current execution priority |
| mem_req_o | output | 1 | Access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | AW | Access address |
| mem_reg_o | output | clog2(NREG) | Register served by the access |
| mem_ack_i | input | 1 | Access completed |
| mem_dev_i | input | 1 | Region of the current access is Device or Strongly-ordered |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| abandon_o | output | 1 | One-cycle abandonment pulse |
| rst_idx_o | output | clog2(NREG) | Next register index after abandonment |
| rst_addr_o | output | AW | Next address after abandonment |

## Verification
Every 8-bit mask is swept with several acknowledge latencies. This targets an encoder that skips or repeats a register, which shows up as a wrong register or address, and an empty mask that hangs or issues a request. Chains of abandon and resume walk each mask one register at a time. A resume that restarts from the base, or that drops the bit at the resume index, breaks the expected address sequence. Sweeps with the control bit set, with equal and lower exception priority, and with per-register device attributes catch a gate that ignores any one of its conditions and abandons where it must not. The last-access case catches a design that abandons with nothing left to resume.

// File: rtl/burst_xfer_pkg.sv
package burst_xfer_pkg;
  typedef enum logic [0:0] {BX_IDLE = 1'b0, BX_RUN = 1'b1} bx_state_e;
  localparam int unsigned BX_STEP = 4;
endpackage

// File: rtl/bx_pick.sv
module bx_pick #(
  parameter int NREG = 16,
  localparam int IW = $clog2(NREG)
) (
  input  logic [NREG-1:0] vec_i,
  output logic            found_o,
  output logic [IW-1:0]   idx_o
);
  always_comb begin
    found_o = |vec_i;
    idx_o   = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/bx_gate.sv
module bx_gate #(
  parameter int PW = 8
) (
  input  logic          exc_pend_i,
  input  logic [PW-1:0] exc_prio_i,
  input  logic [PW-1:0] cur_prio_i,
  input  logic          no_abandon_i,
  input  logic          dev_i,
  output logic          allow_o
);
  logic outranks;
  assign outranks = exc_pend_i && (exc_prio_i < cur_prio_i);
  assign allow_o  = outranks && !no_abandon_i && !dev_i;
endmodule

// File: rtl/bx_ctrl.sv
module bx_ctrl
  import burst_xfer_pkg::*;
#(
  parameter int NREG = 16,
  parameter int AW   = 32,
  localparam int IW  = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            resume_i,
  input  logic [AW-1:0]   base_addr_i,
  input  logic [NREG-1:0] reg_mask_i,
  input  logic            store_i,
  input  logic [IW-1:0]   resume_idx_i,
  input  logic [AW-1:0]   resume_addr_i,
  input  logic            ack_i,
  input  logic            allow_i,
  input  logic [NREG-1:0] rest_i,
  input  logic            nxt_found_i,
  input  logic [IW-1:0]   nxt_idx_i,
  output logic            run_o,
  output logic [NREG-1:0] mask_o,
  output logic [AW-1:0]   addr_o,
  output logic            we_o,
  output logic            done_o,
  output logic            abandon_o,
  output logic [IW-1:0]   rst_idx_o,
  output logic [AW-1:0]   rst_addr_o
);
  bx_state_e       state_q;
  logic [NREG-1:0] mask_q, keep, load_mask;
  logic [AW-1:0]   addr_q, addr_inc;
  logic            we_q, done_q, abandon_q;
  logic [IW-1:0]   rst_idx_q;
  logic [AW-1:0]   rst_addr_q;

  always_comb begin
    for (int i = 0; i < NREG; i++) keep[i] = (i >= int'(resume_idx_i));
  end

  assign load_mask = start_i ? reg_mask_i : (reg_mask_i & keep);
  assign addr_inc  = addr_q + AW'(BX_STEP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= BX_IDLE;
      mask_q     <= '0;
      addr_q     <= '0;
      we_q       <= 1'b0;
      done_q     <= 1'b0;
      abandon_q  <= 1'b0;
      rst_idx_q  <= '0;
      rst_addr_q <= '0;
    end else begin
      done_q    <= 1'b0;
      abandon_q <= 1'b0;
      case (state_q)
        BX_IDLE: begin
          if (start_i || resume_i) begin
            mask_q <= load_mask;
            addr_q <= start_i ? base_addr_i : resume_addr_i;
            we_q   <= store_i;
            if (|load_mask) state_q <= BX_RUN;
            else            done_q  <= 1'b1;
          end
        end
        default: begin
          if (ack_i) begin
            mask_q <= rest_i;
            addr_q <= addr_inc;
            if (!nxt_found_i) begin
              done_q  <= 1'b1;
              state_q <= BX_IDLE;
            end else if (allow_i) begin
              // boundary abandonment: publish the resume point
              abandon_q  <= 1'b1;
              rst_idx_q  <= nxt_idx_i;
              rst_addr_q <= addr_inc;
              mask_q     <= '0;
              state_q    <= BX_IDLE;
            end
          end
        end
      endcase
    end
  end

  assign run_o      = (state_q == BX_RUN);
  assign mask_o     = mask_q;
  assign addr_o     = addr_q;
  assign we_o       = we_q;
  assign done_o     = done_q;
  assign abandon_o  = abandon_q;
  assign rst_idx_o  = rst_idx_q;
  assign rst_addr_o = rst_addr_q;
endmodule

// File: rtl/burst_xfer_seq.sv
module burst_xfer_seq #(
  parameter int NREG = 16,
  parameter int AW   = 32,
  parameter int PW   = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    resume_i,
  input  logic [AW-1:0]           base_addr_i,
  input  logic [NREG-1:0]         reg_mask_i,
  input  logic                    store_i,
  input  logic [$clog2(NREG)-1:0] resume_idx_i,
  input  logic [AW-1:0]           resume_addr_i,
  input  logic                    no_abandon_i,
  input  logic                    exc_pend_i,
  input  logic [PW-1:0]           exc_prio_i,
  input  logic [PW-1:0]           cur_prio_i,
  output logic                    mem_req_o,
  output logic                    mem_we_o,
  output logic [AW-1:0]           mem_addr_o,
  output logic [$clog2(NREG)-1:0] mem_reg_o,
  input  logic                    mem_ack_i,
  input  logic                    mem_dev_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic                    abandon_o,
  output logic [$clog2(NREG)-1:0] rst_idx_o,
  output logic [AW-1:0]           rst_addr_o
);
  localparam int IW = $clog2(NREG);

  logic            run, cur_found, nxt_found, allow;
  logic [NREG-1:0] mask_q, cur_hot, rest;
  logic [IW-1:0]   cur_idx, nxt_idx;

  bx_pick #(.NREG(NREG)) u_cur (.vec_i(mask_q), .found_o(cur_found), .idx_o(cur_idx));

  assign cur_hot = {{(NREG-1){1'b0}}, 1'b1} << cur_idx;
  assign rest    = mask_q & ~cur_hot;

  bx_pick #(.NREG(NREG)) u_nxt (.vec_i(rest), .found_o(nxt_found), .idx_o(nxt_idx));

  bx_gate #(.PW(PW)) u_gate (
    .exc_pend_i  (exc_pend_i),
    .exc_prio_i  (exc_prio_i),
    .cur_prio_i  (cur_prio_i),
    .no_abandon_i(no_abandon_i),
    .dev_i       (mem_dev_i),
    .allow_o     (allow)
  );

  bx_ctrl #(.NREG(NREG), .AW(AW)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .resume_i     (resume_i),
    .base_addr_i  (base_addr_i),
    .reg_mask_i   (reg_mask_i),
    .store_i      (store_i),
    .resume_idx_i (resume_idx_i),
    .resume_addr_i(resume_addr_i),
    .ack_i        (mem_ack_i),
    .allow_i      (allow),
    .rest_i       (rest),
    .nxt_found_i  (nxt_found),
    .nxt_idx_i    (nxt_idx),
    .run_o        (run),
    .mask_o       (mask_q),
    .addr_o       (mem_addr_o),
    .we_o         (mem_we_o),
    .done_o       (done_o),
    .abandon_o    (abandon_o),
    .rst_idx_o    (rst_idx_o),
    .rst_addr_o   (rst_addr_o)
  );

  assign mem_req_o = run && cur_found;
  assign mem_reg_o = cur_idx;
  assign busy_o    = run;
endmodule

// File: rtl/bx_chk.sv
module bx_chk #(
  parameter int NREG = 16,
  parameter int AW   = 32,
  parameter int PW   = 8,
  localparam int IW  = $clog2(NREG)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mem_req_o,
  input logic          mem_ack_i,
  input logic [AW-1:0] mem_addr_o,
  input logic [IW-1:0] mem_reg_o,
  input logic          mem_dev_i,
  input logic          no_abandon_i,
  input logic          exc_pend_i,
  input logic [PW-1:0] exc_prio_i,
  input logic [PW-1:0] cur_prio_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          abandon_o
);
  // R3
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_reg_o));
  // R2
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ack_i |=> !mem_req_o || (mem_addr_o == $past(mem_addr_o) + AW'(4)));
  // R2
  reg_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ack_i |=> !mem_req_o || (mem_reg_o > $past(mem_reg_o)));
  // R4
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R4
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && !abandon_o);
  // R5
  abandon_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abandon_o |-> !mem_req_o ##1 !abandon_o);
  // R7
  abandon_normal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abandon_o |-> $past(mem_req_o && mem_ack_i && !mem_dev_i));
  // R6
  abandon_enabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abandon_o |-> !$past(no_abandon_i));
  // R8
  abandon_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abandon_o |-> $past(exc_pend_i && (exc_prio_i < cur_prio_i)));
endmodule

bind burst_xfer_seq bx_chk #(.NREG(NREG), .AW(AW), .PW(PW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mem_req_o   (mem_req_o),
  .mem_ack_i   (mem_ack_i),
  .mem_addr_o  (mem_addr_o),
  .mem_reg_o   (mem_reg_o),
  .mem_dev_i   (mem_dev_i),
  .no_abandon_i(no_abandon_i),
  .exc_pend_i  (exc_pend_i),
  .exc_prio_i  (exc_prio_i),
  .cur_prio_i  (cur_prio_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .abandon_o   (abandon_o)
);

// File: tb/sim_burst_xfer_seq.sv
`timescale 1ns/1ps
module sim_burst_xfer_seq;
  localparam int NR = 8;
  localparam int AW = 32;
  localparam int PW = 3;
  localparam int IW = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_ni, start_i, resume_i, store_i, no_abandon_i, exc_pend_i;
  logic [AW-1:0] base_addr_i, resume_addr_i;
  logic [NR-1:0] reg_mask_i;
  logic [IW-1:0] resume_idx_i;
  logic [PW-1:0] exc_prio_i, cur_prio_i;
  logic mem_req_o, mem_we_o, mem_ack_i, mem_dev_i, busy_o, done_o, abandon_o;
  logic [AW-1:0] mem_addr_o, rst_addr_o;
  logic [IW-1:0] mem_reg_o, rst_idx_o;
  logic [NR-1:0] dev_mask;

  int checks = 0;
  int fails  = 0;

  burst_xfer_seq #(.NREG(NR), .AW(AW), .PW(PW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .resume_i(resume_i),
    .base_addr_i(base_addr_i), .reg_mask_i(reg_mask_i), .store_i(store_i),
    .resume_idx_i(resume_idx_i), .resume_addr_i(resume_addr_i),
    .no_abandon_i(no_abandon_i), .exc_pend_i(exc_pend_i),
    .exc_prio_i(exc_prio_i), .cur_prio_i(cur_prio_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_reg_o(mem_reg_o), .mem_ack_i(mem_ack_i), .mem_dev_i(mem_dev_i),
    .busy_o(busy_o), .done_o(done_o), .abandon_o(abandon_o),
    .rst_idx_o(rst_idx_o), .rst_addr_o(rst_addr_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit preempt();
    return exc_pend_i && (exc_prio_i < cur_prio_i) && !no_abandon_i;
  endfunction

  task automatic run_op(input bit rs, input logic [NR-1:0] mask, input logic [AW-1:0] a0,
                        input logic [IW-1:0] i0, input bit st, input int lat, input bit poke,
                        output bit ab, output logic [IW-1:0] ni, output logic [AW-1:0] na);
    int lst[NR];
    int n = 0;
    for (int i = 0; i < NR; i++)
      if (mask[i] && (!rs || i >= int'(i0))) begin lst[n] = i; n++; end
    ab = 1'b0; ni = '0; na = '0;
    @(negedge clk);
    start_i = !rs; resume_i = rs; base_addr_i = a0; resume_addr_i = a0;
    resume_idx_i = i0; reg_mask_i = mask; store_i = st;
    @(negedge clk);
    start_i = 1'b0; resume_i = 1'b0;
    if (n == 0) begin
      chk(done_o === 1'b1, "R4 empty mask done", 32'(done_o), 1);
      chk(mem_req_o === 1'b0, "R4 empty mask no request", 32'(mem_req_o), 0);
      @(negedge clk);
      chk(done_o === 1'b0, "R4 done single cycle", 32'(done_o), 0);
      return;
    end
    for (int k = 0; k < n; k++) begin
      for (int w = 0; w <= lat; w++) begin
        chk(mem_req_o === 1'b1 && busy_o === 1'b1, "R2 request", 32'(mem_req_o), 1);
        if (w > 0)
          chk(mem_addr_o === a0 + 32'(4 * k), poke ? "R11 start while busy ignored" : "R3 held address",
              mem_addr_o, a0 + 32'(4 * k));
        else
          chk(mem_addr_o === a0 + 32'(4 * k), rs ? "R10 resume address" : "R2 address",
              mem_addr_o, a0 + 32'(4 * k));
        chk(32'(mem_reg_o) === 32'(lst[k]), rs ? "R10 resume register" : "R2 register",
            32'(mem_reg_o), 32'(lst[k]));
        chk(mem_we_o === st, "R2 direction", 32'(mem_we_o), 32'(st));
        mem_dev_i = dev_mask[lst[k]];
        if (poke && w == 0 && lat > 0) begin
          start_i = 1'b1; resume_i = 1'b1; base_addr_i = 32'hdead_0000; reg_mask_i = '1;
        end else begin
          start_i = 1'b0; resume_i = 1'b0;
        end
        mem_ack_i = (w == lat);
        @(negedge clk);
      end
      mem_ack_i = 1'b0; start_i = 1'b0; resume_i = 1'b0;
      if (k == n - 1) begin
        chk(done_o === 1'b1 && abandon_o === 1'b0, preempt() ? "R9 last access completes" : "R4 done",
            32'(done_o), 1);
        chk(busy_o === 1'b0 && mem_req_o === 1'b0, "R4 idle after done", 32'(busy_o), 0);
        @(negedge clk);
        chk(done_o === 1'b0, "R4 done single cycle", 32'(done_o), 0);
        return;
      end
      if (preempt() && !dev_mask[lst[k]]) begin
        chk(abandon_o === 1'b1 && mem_req_o === 1'b0, "R5 abandon pulse", 32'(abandon_o), 1);
        chk(32'(rst_idx_o) === 32'(lst[k+1]), "R5 restart index", 32'(rst_idx_o), 32'(lst[k+1]));
        chk(rst_addr_o === a0 + 32'(4 * (k + 1)), "R5 restart address", rst_addr_o, a0 + 32'(4 * (k + 1)));
        ab = 1'b1; ni = IW'(lst[k+1]); na = a0 + 32'(4 * (k + 1));
        @(negedge clk);
        chk(abandon_o === 1'b0, "R5 abandon single cycle", 32'(abandon_o), 0);
        return;
      end
      chk(abandon_o === 1'b0,
          no_abandon_i ? "R6 control bit blocks" : (exc_prio_i >= cur_prio_i) ? "R8 priority blocks" : "R7 device blocks",
          32'(abandon_o), 0);
    end
  endtask

  task automatic run_chain(input logic [NR-1:0] m, input logic [AW-1:0] base, input bit st, input int lat);
    bit ab;
    logic [IW-1:0] ni;
    logic [AW-1:0] na;
    run_op(1'b0, m, base, '0, st, lat, 1'b0, ab, ni, na);
    while (ab) run_op(1'b1, m, na, ni, st, lat, 1'b0, ab, ni, na);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit ab;
    logic [IW-1:0] ni;
    logic [AW-1:0] na;
    rst_ni = 1'b0; start_i = 1'b0; resume_i = 1'b0; store_i = 1'b0;
    base_addr_i = '0; resume_addr_i = '0; reg_mask_i = '0; resume_idx_i = '0;
    no_abandon_i = 1'b0; exc_pend_i = 1'b0; exc_prio_i = '0; cur_prio_i = '0;
    mem_ack_i = 1'b0; mem_dev_i = 1'b0; dev_mask = '0;
    repeat (3) @(negedge clk);
    // R1
    chk(busy_o === 1'b0 && mem_req_o === 1'b0, "R1 reset idle", 32'(busy_o), 0);
    chk(done_o === 1'b0 && abandon_o === 1'b0, "R1 reset pulses low", 32'(done_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R2 R4 R11: every mask, no exception
    for (int m = 0; m < 256; m++)
      run_op(1'b0, NR'(m), 32'h1000 + 32'(m * 64), '0, m[0], m % 3, (m % 5) == 1, ab, ni, na);

    // R5 R9 R10: abandon after each access, then resume
    exc_pend_i = 1'b1; exc_prio_i = 3'd1; cur_prio_i = 3'd4;
    for (int m = 0; m < 256; m++) run_chain(NR'(m), 32'h8000 + 32'(m * 128), m[1], m % 2);

    // R6: control bit set
    no_abandon_i = 1'b1;
    for (int m = 0; m < 256; m += 3) begin
      run_op(1'b0, NR'(m), 32'h2000, '0, 1'b0, 0, 1'b0, ab, ni, na);
      chk(!ab, "R6 no abandonment", 32'(ab), 0);
    end
    no_abandon_i = 1'b0;

    // R8: equal or lower urgency
    for (int m = 0; m < 256; m += 3) begin
      exc_prio_i = m[0] ? 3'd4 : 3'd6;
      run_op(1'b0, NR'(m), 32'h3000, '0, 1'b1, 0, 1'b0, ab, ni, na);
      chk(!ab, "R8 no abandonment", 32'(ab), 0);
    end
    exc_prio_i = 3'd1;

    // R7: device regions per register
    for (int m = 0; m < 256; m += 5) begin
      dev_mask = NR'(m) ^ 8'h5a;
      run_chain(NR'(m), 32'h4000, 1'b0, 1);
    end
    dev_mask = '0;
    exc_pend_i = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule